// File: doc/BRIEF.md
# Synchronous two-port 4K x 9 static memory

This block is a 4096-word by 9-bit storage array with two fully independent access ports, called left and right. Each port has its own clock, active-low asynchronous reset, active-low clock enable, active-low chip enable, read/write select, asynchronous active-low output enable, 12-bit address, 9-bit write data and 9-bit read data. The ninth bit is ordinary storage; any parity use is up to the surrounding logic.

Every port input is captured on that port's rising clock edge. An access captured at edge k takes effect at edge k+1: a write lands in the array there, and a read loads the port's output register there. The tri-state output of a real bus is modelled as a data vector plus a drive flag. The drive flag is high only after a read, and only while output enable is low. When both ports write the same word in the same cycle, the left port's data is kept and a one-cycle collision flag is raised. The priority and the collision flag are defined for ports that share one clock.

Top module: `dpr_sync_ram`

## Requirements
- R1: The array holds 2^12 words of 9 bits. Both ports can read or write different words in the same cycle without affecting each other.
- R2: A read captured at edge k (chip enable low, rw high) drives the stored word after edge k+1, with the drive flag at 1. After edge k alone, the drive flag is still 0.
- R3: A write captured at edge k (chip enable low, rw low) stores the captured data at the captured address at edge k+1. A later read returns that data. A write cycle never sets the drive flag.
- R4: While clock enable is high at an edge, the address and write-data registers keep their old contents, but chip enable and rw still load. A read issued with a stalled address returns the word at the old address.
- R5: After reset, a port makes no access at all until clock enable has been sampled low at least once. Before that, reads do not drive and writes do not change the array.
- R6: Chip enable sampled high deselects the port. No word is written, and the drive flag is 0 after the following edge.
- R7: Output enable acts without a clock. While it is high, the drive flag is 0. When it returns low, the registered read word is driven again, unchanged.
- R8: If one port writes a word in the same cycle that the other port reads it, the reader returns the old word. Its next read of that word returns the new one.
- R9: If both ports write the same address in the same cycle, the left data is stored. The collision flag is 1 after edge k+1 and back to 0 after edge k+2, unless another collision follows.
- R10: Reset low clears the port's registered control state to deselected: no drive, and collision flag 0 on the left reset. Reset does not clear the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l_i | input | 1 | Left port clock |
| rst_l_ni | input | 1 | Left port asynchronous reset, active low |
| cke_l_ni | input | 1 | Left clock enable for address/data registers, active low |
| ce_l_ni | input | 1 | Left chip enable, active low |
| rw_l_i | input | 1 | Left access type: 1 read, 0 write |
| oe_l_ni | input | 1 | Left asynchronous output enable, active low |
| addr_l_i | input | 12 | Left word address |
| wdata_l_i | input | 9 | Left write data |
| rdata_l_o | output | 9 | Left read data |
| rdata_en_l_o | output | 1 | Left read data drive flag (0 models high impedance) |
| clk_r_i | input | 1 | Right port clock |
| rst_r_ni | input | 1 | Right port asynchronous reset, active low |
| cke_r_ni | input | 1 | Right clock enable for address/data registers, active low |
| ce_r_ni | input | 1 | Right chip enable, active low |
| rw_r_i | input | 1 | Right access type: 1 read, 0 write |
| oe_r_ni | input | 1 | Right asynchronous output enable, active low |
| addr_r_i | input | 12 | Right word address |
| wdata_r_i | input | 9 | Right write data |
| rdata_r_o | output | 9 | Right read data |
| rdata_en_r_o | output | 1 | Right read data drive flag (0 models high impedance) |
| coll_o | output | 1 | Same-address write collision, one cycle, left clock domain |

## Verification
The hardest states to reach from the ports are the cross-port ones: the same-cycle write/read overlap and the double write to one address. Each needs both ports' captured requests to line up on one edge. The bench drives both ports from one clock and sets their inputs together on a single falling edge, so both requests are captured at the same rising edge. The clock-enable stall and the unprimed state after reset are reached by holding clock enable high across a captured access. A later read then shows whether the array or the output register was touched.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int unsigned NUM_PORTS = 2;

  typedef enum logic {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } side_e;

  // equal copy flags mean the left bank holds the newest word
  function automatic logic left_is_newest(input logic flag_l, input logic flag_r);
    return flag_l == flag_r;
  endfunction
endpackage

// File: rtl/dpr_port_front.sv
module dpr_port_front #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cke_ni,
  input  logic          ce_ni,
  input  logic          rw_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          rd_o,
  output logic          wr_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  logic          primed_q;
  logic          ce_n_q;
  logic          rw_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0;
      ce_n_q   <= 1'b1;
      rw_q     <= 1'b1;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else begin
      ce_n_q <= ce_ni;
      rw_q   <= rw_i;
      if (!cke_ni) begin
        primed_q <= 1'b1;
        addr_q   <= addr_i;
        wdata_q  <= wdata_i;
      end
    end
  end

  logic sel;
  assign sel     = primed_q & ~ce_n_q;
  assign rd_o    = sel & rw_q;
  assign wr_o    = sel & ~rw_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
endmodule

// File: rtl/dpr_bank.sv
module dpr_bank #(
  parameter int unsigned AW  = 12,
  parameter int unsigned DW  = 9,
  parameter bit          INV = 1'b0
) (
  input  logic                clk_i,
  input  logic                we_i,
  input  logic [AW-1:0]       waddr_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic                peer_flag_i,
  input  logic [1:0][AW-1:0]  raddr_i,
  output logic [1:0][DW-1:0]  rdata_o,
  output logic [1:0]          rflag_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] flag;

  // left bank copies the peer flag, right bank inverts it
  always_ff @(posedge clk_i) begin
    if (we_i) begin
      mem[waddr_i]  <= wdata_i;
      flag[waddr_i] <= INV ? ~peer_flag_i : peer_flag_i;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    assign rdata_o[p] = mem[raddr_i[p]];
    assign rflag_o[p] = flag[raddr_i[p]];
  end
endmodule

// File: rtl/dpr_read_stage.sv
module dpr_read_stage #(
  parameter int unsigned DW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic [DW-1:0] data_l_i,
  input  logic [DW-1:0] data_r_i,
  input  logic          flag_l_i,
  input  logic          flag_r_i,
  input  logic          oe_ni,
  output logic [DW-1:0] rdata_o,
  output logic          rdata_en_o
);
  import dpr_pkg::*;

  logic          act_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      data_q <= '0;
    end else begin
      act_q <= rd_i;
      if (rd_i) data_q <= left_is_newest(flag_l_i, flag_r_i) ? data_l_i : data_r_i;
    end
  end

  assign rdata_o    = data_q;
  assign rdata_en_o = act_q & ~oe_ni;
endmodule

// File: rtl/dpr_sync_ram.sv
module dpr_sync_ram #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 9
) (
  input  logic          clk_l_i,
  input  logic          rst_l_ni,
  input  logic          cke_l_ni,
  input  logic          ce_l_ni,
  input  logic          rw_l_i,
  input  logic          oe_l_ni,
  input  logic [AW-1:0] addr_l_i,
  input  logic [DW-1:0] wdata_l_i,
  output logic [DW-1:0] rdata_l_o,
  output logic          rdata_en_l_o,
  input  logic          clk_r_i,
  input  logic          rst_r_ni,
  input  logic          cke_r_ni,
  input  logic          ce_r_ni,
  input  logic          rw_r_i,
  input  logic          oe_r_ni,
  input  logic [AW-1:0] addr_r_i,
  input  logic [DW-1:0] wdata_r_i,
  output logic [DW-1:0] rdata_r_o,
  output logic          rdata_en_r_o,
  output logic          coll_o
);
  import dpr_pkg::*;

  logic [1:0]                clk, rst_n, cke_n, ce_n, rw, oe_n;
  logic [1:0][AW-1:0]        addr_in, addr_q;
  logic [1:0][DW-1:0]        wd_in, wd_q, rdata;
  logic [1:0]                rd, wr, we, rden;
  logic [1:0][1:0][DW-1:0]   bank_rd;
  logic [1:0][1:0]           bank_fl;
  logic                      coll_now;
  logic                      coll_q;

  assign clk     = {clk_r_i, clk_l_i};
  assign rst_n   = {rst_r_ni, rst_l_ni};
  assign cke_n   = {cke_r_ni, cke_l_ni};
  assign ce_n    = {ce_r_ni, ce_l_ni};
  assign rw      = {rw_r_i, rw_l_i};
  assign oe_n    = {oe_r_ni, oe_l_ni};
  assign addr_in = {addr_r_i, addr_l_i};
  assign wd_in   = {wdata_r_i, wdata_l_i};

  assign coll_now = wr[SIDE_L] & wr[SIDE_R] & (addr_q[SIDE_L] == addr_q[SIDE_R]);

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    dpr_port_front #(.AW(AW), .DW(DW)) i_front (
      .clk_i   (clk[g]),
      .rst_ni  (rst_n[g]),
      .cke_ni  (cke_n[g]),
      .ce_ni   (ce_n[g]),
      .rw_i    (rw[g]),
      .addr_i  (addr_in[g]),
      .wdata_i (wd_in[g]),
      .rd_o    (rd[g]),
      .wr_o    (wr[g]),
      .addr_o  (addr_q[g]),
      .wdata_o (wd_q[g])
    );

    if (g == 0) begin : g_we_l
      assign we[g] = wr[g];
    end else begin : g_we_r
      // left wins a same-address double write
      assign we[g] = wr[g] & ~coll_now;
    end

    dpr_bank #(.AW(AW), .DW(DW), .INV(g == 1)) i_bank (
      .clk_i       (clk[g]),
      .we_i        (we[g]),
      .waddr_i     (addr_q[g]),
      .wdata_i     (wd_q[g]),
      .peer_flag_i (bank_fl[1-g][g]),
      .raddr_i     (addr_q),
      .rdata_o     (bank_rd[g]),
      .rflag_o     (bank_fl[g])
    );

    dpr_read_stage #(.DW(DW)) i_rd (
      .clk_i      (clk[g]),
      .rst_ni     (rst_n[g]),
      .rd_i       (rd[g]),
      .data_l_i   (bank_rd[0][g]),
      .data_r_i   (bank_rd[1][g]),
      .flag_l_i   (bank_fl[0][g]),
      .flag_r_i   (bank_fl[1][g]),
      .oe_ni      (oe_n[g]),
      .rdata_o    (rdata[g]),
      .rdata_en_o (rden[g])
    );
  end

  always_ff @(posedge clk_l_i or negedge rst_l_ni) begin
    if (!rst_l_ni) coll_q <= 1'b0;
    else           coll_q <= coll_now;
  end

  assign rdata_l_o    = rdata[SIDE_L];
  assign rdata_r_o    = rdata[SIDE_R];
  assign rdata_en_l_o = rden[SIDE_L];
  assign rdata_en_r_o = rden[SIDE_R];
  assign coll_o       = coll_q;
endmodule

// File: rtl/dpr_sync_ram_chk.sv
module dpr_sync_ram_chk #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 9
) (
  input logic          clk_l_i,
  input logic          rst_l_ni,
  input logic          cke_l_ni,
  input logic          ce_l_ni,
  input logic          rw_l_i,
  input logic          oe_l_ni,
  input logic [AW-1:0] addr_l_i,
  input logic [DW-1:0] wdata_l_i,
  input logic [DW-1:0] rdata_l_o,
  input logic          rdata_en_l_o,
  input logic          clk_r_i,
  input logic          rst_r_ni,
  input logic          cke_r_ni,
  input logic          ce_r_ni,
  input logic          rw_r_i,
  input logic          oe_r_ni,
  input logic [AW-1:0] addr_r_i,
  input logic [DW-1:0] wdata_r_i,
  input logic [DW-1:0] rdata_r_o,
  input logic          rdata_en_r_o,
  input logic          coll_o
);
  assert_oe_gate_l_R7: assert property (@(posedge clk_l_i) disable iff (!rst_l_ni)
    oe_l_ni |-> !rdata_en_l_o);
  assert_oe_gate_r_R7: assert property (@(posedge clk_r_i) disable iff (!rst_r_ni)
    oe_r_ni |-> !rdata_en_r_o);

  assert_desel_quiet_l_R6: assert property (@(posedge clk_l_i) disable iff (!rst_l_ni)
    ce_l_ni |-> ##2 !rdata_en_l_o);
  assert_desel_quiet_r_R6: assert property (@(posedge clk_r_i) disable iff (!rst_r_ni)
    ce_r_ni |-> ##2 !rdata_en_r_o);

  assert_write_quiet_l_R3: assert property (@(posedge clk_l_i) disable iff (!rst_l_ni)
    (!ce_l_ni && !rw_l_i) |-> ##2 !rdata_en_l_o);
  assert_write_quiet_r_R3: assert property (@(posedge clk_r_i) disable iff (!rst_r_ni)
    (!ce_r_ni && !rw_r_i) |-> ##2 !rdata_en_r_o);

  assert_reset_quiet_l_R10: assert property (@(posedge clk_l_i)
    !rst_l_ni |-> (!rdata_en_l_o && !coll_o));
  assert_reset_quiet_r_R10: assert property (@(posedge clk_r_i)
    !rst_r_ni |-> !rdata_en_r_o);
endmodule

bind dpr_sync_ram dpr_sync_ram_chk #(.AW(AW), .DW(DW)) i_chk (.*);

// File: tb/test_dpr_sync_ram.sv
module test_dpr_sync_ram;
  localparam int AW = 12;
  localparam int DW = 9;
  localparam int VN = 10;
  // {side(1), rw(1), addr(12), data(9)}; side 0 left, rw 1 read
  localparam logic [22:0] VEC [VN] = '{
    {1'b0, 1'b0, 12'h000, 9'h1A5},
    {1'b1, 1'b0, 12'hFFF, 9'h05A},
    {1'b0, 1'b0, 12'h7FF, 9'h100},
    {1'b1, 1'b0, 12'h800, 9'h0FF},
    {1'b1, 1'b1, 12'h000, 9'h000},
    {1'b0, 1'b1, 12'hFFF, 9'h000},
    {1'b1, 1'b1, 12'h7FF, 9'h000},
    {1'b0, 1'b1, 12'h800, 9'h000},
    {1'b1, 1'b0, 12'h000, 9'h033},
    {1'b0, 1'b1, 12'h000, 9'h000}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic               rst_n;
  logic [1:0]         cke_n, ce_n, rw, oe_n;
  logic [1:0][AW-1:0] addr;
  logic [1:0][DW-1:0] wd;
  logic [DW-1:0]      rdata_l, rdata_r;
  logic               en_l, en_r, coll;

  logic [DW-1:0] model [1<<AW];
  int total = 0;
  int bad = 0;

  dpr_sync_ram #(.AW(AW), .DW(DW)) i_dpr_sync_ram (
    .clk_l_i(clk), .rst_l_ni(rst_n), .cke_l_ni(cke_n[0]), .ce_l_ni(ce_n[0]),
    .rw_l_i(rw[0]), .oe_l_ni(oe_n[0]), .addr_l_i(addr[0]), .wdata_l_i(wd[0]),
    .rdata_l_o(rdata_l), .rdata_en_l_o(en_l),
    .clk_r_i(clk), .rst_r_ni(rst_n), .cke_r_ni(cke_n[1]), .ce_r_ni(ce_n[1]),
    .rw_r_i(rw[1]), .oe_r_ni(oe_n[1]), .addr_r_i(addr[1]), .wdata_r_i(wd[1]),
    .rdata_r_o(rdata_r), .rdata_en_r_o(en_r), .coll_o(coll)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rd_of(input bit s);
    return s ? rdata_r : rdata_l;
  endfunction
  function automatic logic en_of(input bit s);
    return s ? en_r : en_l;
  endfunction

  task automatic set_req(input bit s, input logic r, input logic [AW-1:0] a, input logic [DW-1:0] d);
    ce_n[s] = 1'b0; rw[s] = r; addr[s] = a; wd[s] = d;
  endtask

  task automatic idle();
    ce_n = 2'b11; rw = 2'b11;
  endtask

  // one access on one port; checks read latency and result
  task automatic do_op(input bit s, input logic r, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input string tag);
    set_req(s, r, a, d);
    @(negedge clk);
    idle();
    if (r) chk({tag, " R2 not yet driven"}, 16'(en_of(s)), 16'h0);
    @(negedge clk);
    if (r) begin
      chk({tag, " R2 drive"}, 16'(en_of(s)), 16'h1);
      chk({tag, " data"}, 16'(rd_of(s)), 16'(model[a]));
    end else begin
      model[a] = d;
      chk({tag, " R3 no drive on write"}, 16'(en_of(s)), 16'h0);
    end
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cke_n = 2'b11; oe_n = 2'b00; addr = '0; wd = '0;
    idle();
    repeat (3) @(negedge clk);
    chk("R10 reset drive l", 16'(en_l), 16'h0);
    chk("R10 reset drive r", 16'(en_r), 16'h0);
    chk("R10 reset coll", 16'(coll), 16'h0);
    rst_n = 1'b1;

    // R5: clock enable never low yet
    set_req(0, 1'b1, 12'h000, '0);
    @(negedge clk); idle();
    @(negedge clk);
    chk("R5 unprimed read no drive", 16'(en_l), 16'h0);
    cke_n = 2'b00;
    @(negedge clk);

    for (int i = 0; i < VN; i++) begin
      do_op(VEC[i][22], VEC[i][21], VEC[i][20:9], VEC[i][8:0], "R1 R3 vector");
    end

    // R1: both ports read at once
    set_req(0, 1'b1, 12'h7FF, '0);
    set_req(1, 1'b1, 12'hFFF, '0);
    @(negedge clk); idle();
    @(negedge clk);
    chk("R1 dual read l", 16'(rdata_l), 16'h100);
    chk("R1 dual read r", 16'(rdata_r), 16'h05A);

    // R4: stalled address
    set_req(0, 1'b1, 12'h000, '0);
    @(negedge clk);
    cke_n[0] = 1'b1; set_req(0, 1'b1, 12'h7FF, '0);
    @(negedge clk);
    chk("R4 first read", 16'(rdata_l), 16'h033);
    idle(); cke_n[0] = 1'b0;
    @(negedge clk);
    chk("R4 stalled read drive", 16'(en_l), 16'h1);
    chk("R4 stalled read keeps old address", 16'(rdata_l), 16'h033);

    // R6: deselected write
    ce_n[0] = 1'b1; rw[0] = 1'b0; addr[0] = 12'h000; wd[0] = 9'h155;
    @(negedge clk); idle();
    @(negedge clk);
    chk("R6 deselect no drive", 16'(en_l), 16'h0);
    do_op(0, 1'b1, 12'h000, '0, "R6 word unchanged");

    // R7: output enable
    set_req(0, 1'b1, 12'hFFF, '0);
    @(negedge clk); idle();
    @(negedge clk);
    oe_n[0] = 1'b1; #1;
    chk("R7 oe high no drive", 16'(en_l), 16'h0);
    oe_n[0] = 1'b0; #1;
    chk("R7 oe low drive", 16'(en_l), 16'h1);
    chk("R7 data kept", 16'(rdata_l), 16'h05A);

    // R8: write/read overlap
    do_op(0, 1'b0, 12'h123, 9'h011, "R8 setup");
    set_req(0, 1'b0, 12'h123, 9'h0AA);
    set_req(1, 1'b1, 12'h123, '0);
    @(negedge clk); idle();
    @(negedge clk);
    chk("R8 reader sees old word", 16'(rdata_r), 16'h011);
    model[12'h123] = 9'h0AA;
    do_op(1, 1'b1, 12'h123, '0, "R8 new word next read");

    // R9: double write collision
    set_req(0, 1'b0, 12'h456, 9'h1C3);
    set_req(1, 1'b0, 12'h456, 9'h03C);
    @(negedge clk); idle();
    chk("R9 coll not yet", 16'(coll), 16'h0);
    @(negedge clk);
    chk("R9 coll raised", 16'(coll), 16'h1);
    @(negedge clk);
    chk("R9 coll one cycle", 16'(coll), 16'h0);
    model[12'h456] = 9'h1C3;
    do_op(0, 1'b1, 12'h456, '0, "R9 left data kept l");
    do_op(1, 1'b1, 12'h456, '0, "R9 left data kept r");

    // R10 / R5: mid-run reset keeps memory; unprimed write ignored
    set_req(0, 1'b1, 12'h000, '0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0; cke_n = 2'b11; idle(); #1;
    chk("R10 async reset drops drive", 16'(en_l), 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    set_req(0, 1'b0, 12'h000, 9'h1FF);
    @(negedge clk); idle();
    @(negedge clk);
    cke_n = 2'b00;
    @(negedge clk);
    do_op(0, 1'b1, 12'h000, '0, "R10 R5 memory kept, unprimed write ignored");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule